// File: doc/BRIEF.md
# Phase-offset NCO waveform generator

This block is a numerically controlled oscillator that produces a digital amplitude word for a downstream converter. A wide phase accumulator grows by a programmable frequency step on every clock, wrapping modulo its width. The top bits of the accumulator are then shifted by a programmable phase offset. The shifted phase drives one of three shapers: a sine taken from a quarter-wave table, a triangle, or a square.

The output frequency is `f_clk * step / 2^ACC_W`. With the default 28-bit accumulator, the resolution is the clock divided by 2^28, which is about 0.1 Hz from a 25 MHz clock. Any step from 0 up to half the clock, 2^27, is usable.

Configuration uses a simple write port, one register per write. Address 0 holds the frequency step. Address 1 holds the phase offset in the low 12 bits. Address 2 holds the waveform select in the low 2 bits. Address 3 is unused.

Top module: `nco_wavegen`

## Requirements
- R1: While `rst` is high, the accumulator and the three configuration registers are cleared to zero, and `wave_o` reads 0 after each reset edge.
- R2: On every clock out of reset, the accumulator grows by the frequency register, modulo 2^28.
- R3: The shaped phase p is the accumulator's top 12 bits plus the 12-bit phase offset, modulo 4096.
- R4: With select 0 (sine), `wave_o` is 512 + round(511*sin(2π(p+0.5)/4096)) when the sine is non-negative. Otherwise it is 511 − round(−511*sin(2π(p+0.5)/4096)).
- R5: With select 1 (triangle), `wave_o` is p[10:0] / 2 when p[11]=0. When p[11]=1 it is (2047 − p[10:0]) / 2.
- R6: With select 2 or 3 (square), `wave_o` is 1023 when p[11]=1 and 0 when p[11]=0.
- R7: A new frequency step written on one clock is first added at the next clock, and the accumulator keeps its value across the change (no phase jump).
- R8: A step of 2^27 (half the clock rate) in square mode gives an output that toggles on every clock.
- R9: A write to address 3 leaves frequency, phase offset and waveform select unchanged.
- R10: `wave_o` is registered: a configuration write updates its register at one clock, and the output reflects the new value at the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register select: 0 step, 1 offset, 2 waveform, 3 unused |
| cfg_wdata | input | 28 | Write data |
| wave_o | output | 10 | Amplitude word, offset binary |

## Verification
A wrong accumulator shows up as a growing drift of `wave_o` away from the reference sequence. The drift starts one clock after the first bad add. Because the reference keeps running instead of resynchronising, the error never heals.

A wrong table entry, quadrant fold or offset adder shows up as a single off-value sample the next clock after the faulty phase is reached. The sweeps therefore use steps that visit all four quadrants. A misrouted write is seen within two clocks as an output that moves when it should stay constant.

// File: rtl/nco_wavegen.sv
module nco_wavegen #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [ACC_W-1:0] cfg_wdata,
  output logic [OUT_W-1:0] wave_o
);
  localparam int QA = PH_W - 2;
  localparam int QN = 1 << QA;
  localparam int MW = OUT_W - 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << MW;

  function automatic int quarter_mag(int j);
    real a;
    a = (real'(j) + 0.5) * 3.14159265358979 / (2.0 * real'(QN));
    return $rtoi(real'((1 << MW) - 1) * $sin(a) + 0.5);
  endfunction

  logic [MW-1:0] rom [QN];
  for (genvar j = 0; j < QN; j++) begin : g_rom
    localparam int V = quarter_mag(j);
    assign rom[j] = V[MW-1:0];
  end

  logic [ACC_W-1:0] acc_r, freq_r;
  logic [PH_W-1:0]  phase_r;
  logic [1:0]       mode_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r   <= '0;
      freq_r  <= '0;
      phase_r <= '0;
      mode_r  <= '0;
    end else begin
      acc_r <= acc_r + freq_r;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    freq_r  <= cfg_wdata;
          2'd1:    phase_r <= cfg_wdata[PH_W-1:0];
          2'd2:    mode_r  <= cfg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  logic [PH_W-1:0]  ph;
  logic [QA-1:0]    qidx;
  logic [MW-1:0]    mag;
  logic [PH_W-2:0]  fold;
  logic [OUT_W-1:0] sine_v, tri_v, sq_v, next_v;

  assign ph     = acc_r[ACC_W-1 -: PH_W] + phase_r;
  assign qidx   = ph[PH_W-2] ? ~ph[QA-1:0] : ph[QA-1:0];
  assign mag    = rom[qidx];
  assign sine_v = ph[PH_W-1] ? (MID - OUT_W'(1) - {1'b0, mag}) : (MID + {1'b0, mag});
  assign fold   = ph[PH_W-1] ? ~ph[PH_W-2:0] : ph[PH_W-2:0];
  assign tri_v  = fold[PH_W-2 -: OUT_W];
  assign sq_v   = {OUT_W{ph[PH_W-1]}};

  always_comb begin
    case (mode_r)
      2'd0:    next_v = sine_v;
      2'd1:    next_v = tri_v;
      default: next_v = sq_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wave_o <= '0;
    else     wave_o <= next_v;
  end
endmodule

module nco_wavegen_chk #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [ACC_W-1:0] acc_r,
  input logic [ACC_W-1:0] freq_r,
  input logic [PH_W-1:0]  phase_r,
  input logic [1:0]       mode_r,
  input logic [OUT_W-1:0] wave_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_r == '0 && freq_r == '0 && phase_r == '0 && mode_r == '0 && wave_o == '0));

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> acc_r == ACC_W'($past(acc_r) + $past(freq_r)));

  assert_square_levels_R6: assert property (@(posedge clk) disable iff (rst)
    mode_r[1] |=> (wave_o == '0 || wave_o == '1));

  assert_unused_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd3) |=> ($stable(freq_r) && $stable(phase_r) && $stable(mode_r)));
endmodule

bind nco_wavegen nco_wavegen_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .acc_r(acc_r),
  .freq_r(freq_r), .phase_r(phase_r), .mode_r(mode_r), .wave_o(wave_o)
);

// File: tb/test_nco_wavegen.sv
module test_nco_wavegen;
  localparam int NV = 8;
  localparam logic [1:0]  VM [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam logic [27:0] VF [NV] = '{28'h0100000, 28'h3456789, 28'h0200000, 28'h5A5A5A5,
                                      28'h0400000, 28'h0123457, 28'hF000001, 28'h7FFFFFF};
  localparam logic [11:0] VP [NV] = '{12'h000, 12'h3FF, 12'h800, 12'h123,
                                      12'h400, 12'hC00, 12'hFFF, 12'h001};

  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [27:0] cfg_wdata = '0;
  logic [9:0]  wave_o;
  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  nco_wavegen i_nco_wavegen (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                             .cfg_wdata(cfg_wdata), .wave_o(wave_o));

  function automatic logic [9:0] exp_wave(logic [11:0] p, logic [1:0] m);
    real s;
    if (m[1]) return p[11] ? 10'd1023 : 10'd0;
    if (m == 2'd1) return p[11] ? 10'((2047 - int'(p[10:0])) / 2) : 10'(int'(p[10:0]) / 2);
    s = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0);
    if (s >= 0.0) return 10'(512 + $rtoi(s + 0.5));
    return 10'(511 - $rtoi(-s + 0.5));
  endfunction

  logic [27:0] m_acc = '0, m_freq = '0;
  logic [11:0] m_ph = '0;
  logic [1:0]  m_mode = '0;
  logic [9:0]  m_out = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_freq <= '0; m_ph <= '0; m_mode <= '0; m_out <= '0;
    end else begin
      m_out <= exp_wave(m_acc[27:16] + m_ph, m_mode);
      m_acc <= m_acc + m_freq;
      if (cfg_we && cfg_addr == 2'd0) m_freq <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1) m_ph <= cfg_wdata[11:0];
      if (cfg_we && cfg_addr == 2'd2) m_mode <= cfg_wdata[1:0];
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk)
    if (cmp_en && !rst)
      check(wave_o == m_out, m_mode == 0 ? "R4 R2 R3" : m_mode == 1 ? "R5 R2 R3" : "R6 R2 R3",
            int'(wave_o), int'(m_out));

  task automatic wr(logic [1:0] a, logic [27:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(wave_o == 10'd0, "R1", int'(wave_o), 0);
    rst = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [9:0] prev;
    do_reset();
    @(negedge clk);
    check(wave_o == 10'd512, "R1 R4", int'(wave_o), 512);

    cmp_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(2'd2, {26'd0, VM[v]});
      wr(2'd1, {16'd0, VP[v]});
      wr(2'd0, VF[v]);
      repeat (60) @(negedge clk);
    end

    // R7: change the step mid-run without reset; reference keeps its phase
    do_reset();
    wr(2'd2, 28'd1);
    wr(2'd0, 28'h0300000);
    repeat (20) @(negedge clk);
    wr(2'd0, 28'h0050000);
    repeat (20) @(negedge clk);
    wr(2'd2, 28'd0);
    wr(2'd0, 28'h1234567);
    repeat (20) @(negedge clk);
    check(wave_o == m_out, "R7", int'(wave_o), int'(m_out));
    cmp_en = 1'b0;

    // R3/R10: fixed phase with zero step, one-cycle output latency
    do_reset();
    repeat (2) @(negedge clk);
    check(wave_o == 10'd512, "R3", int'(wave_o), 512);
    wr(2'd1, 28'd1024);
    check(wave_o == 10'd512, "R10", int'(wave_o), 512);
    @(negedge clk);
    check(wave_o == 10'd1023, "R10 R3", int'(wave_o), 1023);
    wr(2'd1, 28'd3072);
    @(negedge clk);
    check(wave_o == 10'd0, "R3 R4", int'(wave_o), 0);
    wr(2'd2, 28'd1);
    wr(2'd1, 28'd2048);
    @(negedge clk);
    check(wave_o == 10'd1023, "R5", int'(wave_o), 1023);
    wr(2'd1, 28'd0);
    @(negedge clk);
    check(wave_o == 10'd0, "R5", int'(wave_o), 0);
    wr(2'd2, 28'd2);
    wr(2'd1, 28'd2048);
    @(negedge clk);
    check(wave_o == 10'd1023, "R6", int'(wave_o), 1023);

    // R9: address 3 must not alter frequency, offset or select
    wr(2'd3, 28'h8000000);
    wr(2'd3, 28'h0000000);
    repeat (3) @(negedge clk);
    check(wave_o == 10'd1023, "R9", int'(wave_o), 1023);

    // R8: half-rate step toggles every clock in square mode
    do_reset();
    wr(2'd2, 28'd2);
    wr(2'd0, 28'h8000000);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      prev = wave_o;
      @(negedge clk);
      check(wave_o == ~prev, "R8", int'(wave_o), int'(~prev));
    end

    // R1: reset mid-run clears the output
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(wave_o == 10'd0, "R1", int'(wave_o), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(wave_o == 10'd512, "R1", int'(wave_o), 512);
    finish_up();
  end
endmodule